// File: doc/BRIEF.md
# Parallel Flash Command Interpreter

This block models the command logic of a byte-wide parallel NOR flash. It watches a simple synchronous bus and turns the write cycles it sees into one of four operations: return to array reads, enter identification mode, program one byte, or erase the whole array. Every command except reset is guarded by a fixed pair of unlock writes. A wrong write anywhere in a sequence drops the sequence and puts the block back in array-read mode.

Program and erase run as timed background operations on a small internal array. The length of each operation in clock cycles is set by a parameter. While an operation runs, every read returns a status byte instead of array data, and any write is ignored. In identification mode, reads return fixed identity codes and a per-sector protection flag. The block stays in identification mode until a reset command is written.

Top module: `nor_cmd_ctrl`

## Requirements
- R1: After the hardware reset input (`rst_n` low) is released, the block is in array-read mode. The array is blank (every byte 0xFF), and a read returns the byte at index `bus_addr[5:0]` in the same cycle.
- R2: A byte program is four writes: 0xAA to 0x555, then 0x55 to 0x2AA, then 0xA0 to 0x555. The fourth write starts programming of its data at index `bus_addr[5:0]`. Unlock and command addresses compare only `bus_addr[10:0]`.
- R3: A chip erase is six writes: 0xAA to 0x555, 0x55 to 0x2AA, 0x80 to 0x555, 0xAA to 0x555, 0x55 to 0x2AA, then 0x10 to 0x555.
- R4: An erase shows status 0x00 on every read for exactly ERASE_CYC cycles, counted from the cycle after its last write. It then leaves every array byte at 0xFF and returns to array-read mode.
- R5: Programming can only clear bits. The stored byte becomes old AND new, so a 0 bit never returns to 1.
- R6: A program shows status for exactly PROG_CYC cycles, counted from the cycle after the data write. Bit 7 of the status is the inverse of bit 7 of the data being written, and bits 6..0 are 0. After that, a read returns the programmed value and the block is in array-read mode.
- R7: Writes received during a program or an erase have no effect on the array or on command decoding.
- R8: In identification mode, a read with `bus_addr[7:0]` = 0x00 returns 0x01 and a read with `bus_addr[7:0]` = 0x01 returns 0x58. Both codes have odd parity over 8 bits.
- R9: In identification mode, a read with `bus_addr[6]`=0 and `bus_addr[1:0]`=2'b10 returns the protect flag of sector `bus_addr[11:10]`, taken from PROT_MASK, on bit 0, with the other bits 0. Any other identification address returns 0x00.
- R10: Identification mode is entered with the two unlock writes followed by 0x90 to 0x555. It is left only by writing 0xF0, at any address. All other writes are ignored.
- R11: A write that does not match the expected step of a sequence returns the block to array-read mode, and the sequence must restart from the first unlock write.
- R12: While `bus_rd` is low, `bus_rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| bus_addr | input | AW (12) | Byte address for reads and writes |
| bus_wdata | input | 8 | Write data / command byte |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data: array byte, identity code or status |

## Verification
Reads are combinational, so a read result is valid in the same cycle that its address and strobe are applied. The bench drives inputs on the falling edge and samples just after it. A write takes effect on the next rising edge. Status appears in the cycle after the final write of a sequence and lasts exactly PROG_CYC or ERASE_CYC cycles; the bench counts status cycles one falling edge at a time and compares the count with the parameter. A behavioural model steps through the same edges and predicts every read cycle, so no check depends on a guessed settling delay.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

  typedef enum logic [3:0] {
    ST_READ, ST_UL1, ST_UL2, ST_PRG_WAIT,
    ST_ER_SET, ST_ER_UL1, ST_ER_UL2,
    ST_AUTO, ST_BUSY_PRG, ST_BUSY_ERS
  } cmd_state_e;

  localparam logic [7:0]  KEY_A       = 8'hAA;
  localparam logic [7:0]  KEY_B       = 8'h55;
  localparam logic [7:0]  CMD_PRG     = 8'hA0;
  localparam logic [7:0]  CMD_ERS_SET = 8'h80;
  localparam logic [7:0]  CMD_CHIP    = 8'h10;
  localparam logic [7:0]  CMD_ID      = 8'h90;
  localparam logic [7:0]  CMD_RST     = 8'hF0;
  localparam logic [7:0]  MFR_CODE    = 8'h01;
  localparam logic [7:0]  DEV_CODE    = 8'h58;
  localparam logic [10:0] KEY_ADDR_A  = 11'h555;
  localparam logic [10:0] KEY_ADDR_B  = 11'h2AA;

  // Flash cells only discharge: a program can clear bits, never set them.
  function automatic logic [7:0] and_program(input logic [7:0] old_v,
                                             input logic [7:0] new_v);
    return old_v & new_v;
  endfunction

  // Status byte shown while busy: inverse of the target bit 7.
  function automatic logic [7:0] poll_byte(input logic target_b7);
    return {~target_b7, 7'b0};
  endfunction

  // Identification readout from the low address byte.
  function automatic logic [7:0] id_byte(input logic [7:0] lo,
                                         input logic prot);
    if (!lo[6] && lo[1:0] == 2'b10) return {7'b0, prot};
    else if (lo == 8'h00)           return MFR_CODE;
    else if (lo == 8'h01)           return DEV_CODE;
    else                            return 8'h00;
  endfunction

endpackage

// File: rtl/nor_op_timer.sv
module nor_op_timer #(
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_prog,
  input  logic start_erase,
  output logic op_busy,
  output logic op_done
);
  localparam int MAXC  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  logic [CNT_W-1:0] remain;
  logic             active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      remain <= '0;
    end else if (start_prog) begin
      active <= 1'b1;
      remain <= CNT_W'(PROG_CYC - 1);
    end else if (start_erase) begin
      active <= 1'b1;
      remain <= CNT_W'(ERASE_CYC - 1);
    end else if (active) begin
      if (remain == '0) active <= 1'b0;
      else              remain <= remain - 1'b1;
    end
  end

  assign op_busy = active;
  assign op_done = active && (remain == '0);

  // R6: a finished operation leaves the timer idle on the next cycle
  assert_timer_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && !start_prog && !start_erase) |=> !op_busy);

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_cmd_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  input  logic          op_done,
  output cmd_state_e    state,
  output logic          start_prog,
  output logic          start_erase,
  output logic [AW-1:0] prog_addr,
  output logic [7:0]    prog_data
);
  cmd_state_e nxt;
  logic at_a, at_b, key1, key2;

  assign at_a = (addr[10:0] == KEY_ADDR_A);
  assign at_b = (addr[10:0] == KEY_ADDR_B);
  assign key1 = at_a && (wdata == KEY_A);
  assign key2 = at_b && (wdata == KEY_B);

  always_comb begin
    nxt         = state;
    start_prog  = 1'b0;
    start_erase = 1'b0;
    case (state)
      ST_BUSY_PRG, ST_BUSY_ERS: if (op_done) nxt = ST_READ;
      ST_AUTO:     if (wr_en && wdata == CMD_RST) nxt = ST_READ;
      ST_UL1:      if (wr_en) nxt = key2 ? ST_UL2 : ST_READ;
      ST_UL2: if (wr_en) begin
        if (at_a && wdata == CMD_PRG)          nxt = ST_PRG_WAIT;
        else if (at_a && wdata == CMD_ERS_SET) nxt = ST_ER_SET;
        else if (at_a && wdata == CMD_ID)      nxt = ST_AUTO;
        else                                   nxt = ST_READ;
      end
      ST_PRG_WAIT: if (wr_en) begin
        nxt        = ST_BUSY_PRG;
        start_prog = 1'b1;
      end
      ST_ER_SET:   if (wr_en) nxt = key1 ? ST_ER_UL1 : ST_READ;
      ST_ER_UL1:   if (wr_en) nxt = key2 ? ST_ER_UL2 : ST_READ;
      ST_ER_UL2: if (wr_en) begin
        if (at_a && wdata == CMD_CHIP) begin
          nxt         = ST_BUSY_ERS;
          start_erase = 1'b1;
        end else nxt = ST_READ;
      end
      default:     if (wr_en) nxt = key1 ? ST_UL1 : ST_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_READ;
      prog_addr <= '0;
      prog_data <= '0;
    end else begin
      state <= nxt;
      if (start_prog) begin
        prog_addr <= addr;
        prog_data <= wdata;
      end
    end
  end

  // R7: a running operation holds its state until the timer finishes
  assert_busy_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_BUSY_PRG || state == ST_BUSY_ERS) && !op_done)
      |=> (state == $past(state)));

  // R10: identification mode persists unless the reset byte is written
  assert_auto_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_AUTO && !(wr_en && wdata == CMD_RST)) |=> (state == ST_AUTO));

  // R7: the latched program target does not move while busy
  assert_target_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BUSY_PRG) |=> $stable(prog_data));

endmodule

// File: rtl/nor_cell_array.sv
module nor_cell_array
  import nor_cmd_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prog_we,
  input  logic             erase_we,
  input  logic [IDX_W-1:0] prog_idx,
  input  logic [7:0]       prog_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_data
);
  localparam int DEPTH = 1 << IDX_W;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
    end else if (erase_we) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
    end else if (prog_we) begin
      cells[prog_idx] <= and_program(cells[prog_idx], prog_data);
    end
  end

  assign rd_data = cells[rd_idx];

  logic [7:0] target_cell, first_cell, last_cell;
  assign target_cell = cells[prog_idx];
  assign first_cell  = cells[0];
  assign last_cell   = cells[DEPTH-1];

  // R5: programming never raises a bit of the target byte
  assert_and_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    prog_we |=> ((target_cell & ~$past(target_cell)) == 8'h00));

  // R4: an erase leaves the array blank at both ends
  assert_erase_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    erase_we |=> (first_cell == 8'hFF && last_cell == 8'hFF));

endmodule

// File: rtl/nor_cmd_ctrl.sv
module nor_cmd_ctrl
  import nor_cmd_pkg::*;
#(
  parameter int AW        = 12,
  parameter int IDX_W     = 6,
  parameter int SECT_W    = 2,
  parameter logic [(1<<SECT_W)-1:0] PROT_MASK = 4'b0101,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  input  logic          bus_wr,
  input  logic          bus_rd,
  output logic [7:0]    bus_rdata
);
  cmd_state_e    state;
  logic          start_prog, start_erase, op_busy, op_done;
  logic          prog_we, erase_we, prot_bit;
  logic [AW-1:0] prog_addr;
  logic [7:0]    prog_data, cell_rd;

  nor_cmd_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .op_done(op_done), .state(state),
    .start_prog(start_prog), .start_erase(start_erase),
    .prog_addr(prog_addr), .prog_data(prog_data)
  );

  nor_op_timer #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .start_prog(start_prog),
    .start_erase(start_erase), .op_busy(op_busy), .op_done(op_done)
  );

  assign prog_we  = op_done && (state == ST_BUSY_PRG);
  assign erase_we = op_done && (state == ST_BUSY_ERS);

  nor_cell_array #(.IDX_W(IDX_W)) u_array (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .erase_we(erase_we),
    .prog_idx(prog_addr[IDX_W-1:0]), .prog_data(prog_data),
    .rd_idx(bus_addr[IDX_W-1:0]), .rd_data(cell_rd)
  );

  assign prot_bit = PROT_MASK[bus_addr[AW-1 -: SECT_W]];

  always_comb begin
    if (!bus_rd) bus_rdata = 8'h00;
    else begin
      case (state)
        ST_BUSY_PRG: bus_rdata = poll_byte(prog_data[7]);
        ST_BUSY_ERS: bus_rdata = poll_byte(1'b1);
        ST_AUTO:     bus_rdata = id_byte(bus_addr[7:0], prot_bit);
        default:     bus_rdata = cell_rd;
      endcase
    end
  end

  // R6: the timer completes only inside a program or erase
  assert_done_in_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |-> (state == ST_BUSY_PRG || state == ST_BUSY_ERS));

  // R6: the timer runs whenever a busy state is shown
  assert_busy_timed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BUSY_PRG || state == ST_BUSY_ERS) |-> op_busy);

  // R6: status on the bus during a program carries the inverted bit 7
  assert_poll_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BUSY_PRG && bus_rd) |->
      (bus_rdata[6:0] == 7'h00 && bus_rdata[7] != prog_data[7]));

  // R12: an idle read strobe keeps the bus at zero
  assert_idle_bus_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == 8'h00));

endmodule

// File: tb/nor_cmd_ctrl_test.sv
`timescale 1ns/1ps
module nor_cmd_ctrl_test;
  localparam int P_CYC = 8;
  localparam int E_CYC = 40;
  localparam logic [3:0] PROT = 4'b0101;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] b_addr = '0;
  logic [7:0]  b_wdata = '0;
  logic        b_wr = 1'b0;
  logic        b_rd = 1'b0;
  logic [7:0]  rdata;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  nor_cmd_ctrl #(.PROG_CYC(P_CYC), .ERASE_CYC(E_CYC), .PROT_MASK(PROT)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(b_addr), .bus_wdata(b_wdata),
    .bus_wr(b_wr), .bus_rd(b_rd), .bus_rdata(rdata)
  );

  // Behavioural reference model: 0 read, 1 ident, 2 programming, 3 erasing
  int         m_mode, m_pos, m_left;
  logic [5:0] m_pidx;
  logic [7:0] m_pdat;
  logic [7:0] m_mem [64];

  task automatic model_write(input logic [11:0] a, input logic [7:0] d);
    bit ka, kb, at555;
    at555 = (a[10:0] == 11'h555);
    ka = at555 && d == 8'hAA;
    kb = (a[10:0] == 11'h2AA) && d == 8'h55;
    if (m_mode == 1) begin
      if (d == 8'hF0) m_mode = 0;
      return;
    end
    case (m_pos)
      1: m_pos = kb ? 2 : 0;
      2: begin
        m_pos = 0;
        if (at555 && d == 8'hA0) m_pos = 10;
        if (at555 && d == 8'h80) m_pos = 20;
        if (at555 && d == 8'h90) m_mode = 1;
      end
      10: begin
        m_mode = 2; m_left = P_CYC; m_pidx = a[5:0]; m_pdat = d; m_pos = 0;
      end
      20: m_pos = ka ? 21 : 0;
      21: m_pos = kb ? 22 : 0;
      22: begin
        if (at555 && d == 8'h10) begin m_mode = 3; m_left = E_CYC; end
        m_pos = 0;
      end
      default: m_pos = ka ? 1 : 0;
    endcase
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_pos = 0; m_left = 0;
      foreach (m_mem[i]) m_mem[i] = 8'hFF;
    end else if (m_left > 0) begin
      m_left = m_left - 1;
      if (m_left == 0) begin
        if (m_mode == 2) m_mem[m_pidx] = m_mem[m_pidx] & m_pdat;
        else foreach (m_mem[i]) m_mem[i] = 8'hFF;
        m_mode = 0;
      end
    end else if (b_wr) model_write(b_addr, b_wdata);
  end

  function automatic logic [7:0] exp_read(input logic [11:0] a);
    logic [7:0] lo;
    lo = a[7:0];
    if (!b_rd) return 8'h00;
    if (m_mode == 2) return m_pdat[7] ? 8'h00 : 8'h80;
    if (m_mode == 3) return 8'h00;
    if (m_mode == 1) begin
      if (lo[6] == 1'b0 && lo[1:0] == 2'b10) return {7'b0, PROT[a[11:10]]};
      if (lo == 8'h00) return 8'h01;
      if (lo == 8'h01) return 8'h58;
      return 8'h00;
    end
    return m_mem[a[5:0]];
  endfunction

  function automatic string mode_tag();
    case (m_mode)
      1: return "R8";
      2: return "R6";
      3: return "R4";
      default: return b_rd ? "R1" : "R12";
    endcase
  endfunction

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      checks++;
      if (rdata !== exp_read(b_addr)) begin
        errors++;
        $display("FAIL %s cycle compare addr=%h actual=%h expected=%h",
                 mode_tag(), b_addr, rdata, exp_read(b_addr));
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_at(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    b_addr = a; b_wdata = d; b_wr = 1'b1; b_rd = 1'b0;
    @(negedge clk);
    b_wr = 1'b0;
  endtask

  task automatic rd_at(input logic [11:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    b_addr = a; b_rd = 1'b1; b_wr = 1'b0;
    #3;
    chk(tag, rdata, exp);
  endtask

  // Called right after the final write; counts status cycles.
  task automatic poll_busy(input logic [11:0] a, input logic [7:0] status,
                           input logic [7:0] final_v, input int exp_len,
                           input string tag);
    int n;
    n = 0;
    b_addr = a; b_rd = 1'b1;
    #3;
    while (rdata == status && n < 1000) begin
      n++;
      @(negedge clk);
      #3;
    end
    chk(tag, n, exp_len);
    chk(tag, rdata, final_v);
  endtask

  task automatic unlock();
    wr_at(12'h555, 8'hAA);
    wr_at(12'h2AA, 8'h55);
  endtask

  task automatic program_byte(input logic [11:0] a, input logic [7:0] d);
    unlock();
    wr_at(12'h555, 8'hA0);
    wr_at(a, d);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: blank array readable without any command
    rd_at(12'h000, 8'hFF, "R1");
    rd_at(12'h005, 8'hFF, "R1");
    rd_at(12'h03F, 8'hFF, "R1");

    // R2 / R6: program 0x3C, status 0x80 for exactly P_CYC cycles
    program_byte(12'h005, 8'h3C);
    poll_busy(12'h005, 8'h80, 8'h3C, P_CYC, "R6");
    rd_at(12'h005, 8'h3C, "R2");

    // R5: AND-only programming
    program_byte(12'h005, 8'hF0);
    poll_busy(12'h005, 8'h00, 8'h30, P_CYC, "R5");
    rd_at(12'h005, 8'h30, "R5");

    // R7: writes during busy are ignored
    program_byte(12'h007, 8'h81);
    wr_at(12'h555, 8'hAA);
    wr_at(12'h2AA, 8'h55);
    wr_at(12'h555, 8'hA0);
    repeat (6) @(negedge clk);
    wr_at(12'h007, 8'h00);
    rd_at(12'h007, 8'h81, "R7");

    // R11: broken sequences never reach programming
    wr_at(12'h555, 8'hAA);
    wr_at(12'h2AA, 8'h56);
    wr_at(12'h2AA, 8'h55);
    wr_at(12'h555, 8'hA0);
    wr_at(12'h009, 8'h00);
    rd_at(12'h009, 8'hFF, "R11");
    unlock();
    wr_at(12'h555, 8'h33);
    wr_at(12'h009, 8'h00);
    rd_at(12'h009, 8'hFF, "R11");

    // R8 / R9 / R10: identification mode
    unlock();
    wr_at(12'h555, 8'h90);
    rd_at(12'h000, 8'h01, "R8");
    chk("R8", $countones(rdata) % 2, 1);
    rd_at(12'h001, 8'h58, "R8");
    chk("R8", $countones(rdata) % 2, 1);
    rd_at(12'h002, 8'h01, "R9");
    rd_at(12'h402, 8'h00, "R9");
    rd_at(12'h802, 8'h01, "R9");
    rd_at(12'hC02, 8'h00, "R9");
    rd_at(12'h042, 8'h00, "R9");
    wr_at(12'h555, 8'hAA);
    wr_at(12'h2AA, 8'h55);
    wr_at(12'h555, 8'hA0);
    wr_at(12'h000, 8'h00);
    rd_at(12'h000, 8'h01, "R10");
    wr_at(12'h123, 8'hF0);
    rd_at(12'h005, 8'h30, "R10");
    rd_at(12'h000, 8'hFF, "R10");

    // R12: idle read strobe
    @(negedge clk);
    b_rd = 1'b0; b_addr = 12'h005;
    #3;
    chk("R12", rdata, 8'h00);

    // R3 / R4: chip erase
    unlock();
    wr_at(12'h555, 8'h80);
    unlock();
    wr_at(12'h555, 8'h10);
    poll_busy(12'h005, 8'h00, 8'hFF, E_CYC, "R4");
    for (int i = 0; i < 64; i++) rd_at(12'(i), 8'hFF, "R3");

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule